// File: doc/BRIEF.md
# Single-Wire Return-to-One Serial Slave

This block is the device end of a one-pin, open-drain serial link. The host pulls the shared line low to open each bit frame, and the line returns high before the frame ends. The block times every frame from its falling edge using a one-microsecond tick. It assembles bytes least significant bit first. The first byte of a transaction is a command. Its top bit selects the direction and its lower seven bits address a register in an external register file.

On a write command, the next byte goes to that register through a one-cycle write pulse, provided the register file reports the address as valid. On a read command, the block waits a short turnaround and then drives eight frames of its own through a pull-low enable, using the register's byte. Three things return the receiver to waiting for a command: a long low level (a break), a low level released too late (a framing error), and a stall in the middle of a transaction. A write of one of three code values to the command-word register raises a matching one-cycle strobe.

Top module: `swire_slave`

## Requirements
- R1: Bytes travel least significant bit first in both directions; a write command 0x92 followed by data 0xC4 stores 0xC4 at address 0x12, and a later read of 0x12 returns 0xC4 in send order bit0..bit7.
- R2: A command byte with bit 7 = 1 is a write: after eight more valid bits, `reg_wr` pulses for one cycle with `reg_addr` = command bits 6:0 and `reg_wdata` = the received byte; no pulse occurs before the eighth bit.
- R3: A command byte with bit 7 = 0 is a read: 100 µs after the last command bit is accepted, the block loads `reg_rdata`, then sends 8 frames of 200 µs each; every frame pulls low for its first 32 µs and, for a 0 bit, until 100 µs; the first frame starts within 320 µs of the end of the host's command frame.
- R4: A received bit is the line level 70 µs after the falling edge; the bit is accepted once the line is high again at or before 145 µs (a 0 held low for 140 µs or a 1 held low for 60 µs both decode correctly).
- R5: A low level released after 145 µs but before 190 µs is a framing error: the partial byte is dropped and the next bit starts a new command.
- R6: A low level of 190 µs or longer is a break: the partial transaction is dropped, and falling edges are ignored until the line has stayed high for 40 µs; a low pulse during that recovery restarts the 40 µs wait.
- R7: A write to an address for which `addr_ok` is 0 produces no `reg_wr` pulse and leaves the receiver ready for a new command.
- R8: A write to address 0x3F that the register file accepts raises, together with `reg_wr`, `cmd_reset` for data 0x78, `cal_begin` for 0x68 and `cal_end` for 0x60; a write of these codes to another address raises none of them.
- R9: If the line stays high for 1000 µs while a transaction is incomplete, the partial transaction is dropped.
- R10: After reset the line is released and `reg_wr`, `reg_rd` and the three strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| line_in | input | 1 | Level of the shared line, already synchronous to clk |
| pull_low | output | 1 | Enable for the open-drain pull-down on the line |
| reg_addr | output | 7 | Register address taken from the last command |
| reg_wr | output | 1 | One-cycle register write pulse |
| reg_wdata | output | 8 | Data for the write pulse |
| reg_rd | output | 1 | Pulses in the cycle after `reg_rdata` is captured for a read |
| reg_rdata | input | 8 | Register byte at `reg_addr`, combinational |
| addr_ok | input | 1 | High when `reg_addr` names an existing register |
| cmd_reset | output | 1 | Strobe for the reset code to the command-word register |
| cal_begin | output | 1 | Strobe for the calibration-start code |
| cal_end | output | 1 | Strobe for the calibration-stop code |

## Verification
The assertions assume three things. `line_in` is the wired-AND of the host's level and the block's own pull-down. `addr_ok` and `reg_rdata` depend only on `reg_addr`. `us_tick` is a single-cycle pulse. The bench honours all three: it forms the line from its host level and `pull_low`, derives validity and read data from the address alone, and toggles the tick every other clock. The host drives and samples only on falling clock edges, and it keeps every frame within the ranges the requirements name. The only exceptions are the frames that deliberately exercise framing errors, breaks, short recovery and stalls.

// File: rtl/swire_slave.sv
module swire_slave #(
  parameter int T_SAMP    = 70,
  parameter int T_STOP    = 145,
  parameter int T_BREAK   = 190,
  parameter int T_RECOV   = 40,
  parameter int T_TURN    = 100,
  parameter int T_TXLOW   = 32,
  parameter int T_TXDATA  = 100,
  parameter int T_TXCYC   = 200,
  parameter int T_TIMEOUT = 1000,
  parameter logic [6:0] CMDW_ADDR    = 7'h3F,
  parameter logic [7:0] CODE_RST     = 8'h78,
  parameter logic [7:0] CODE_CAL_GO  = 8'h68,
  parameter logic [7:0] CODE_CAL_END = 8'h60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       line_in,
  output logic       pull_low,
  output logic [6:0] reg_addr,
  output logic       reg_wr,
  output logic [7:0] reg_wdata,
  output logic       reg_rd,
  input  logic [7:0] reg_rdata,
  input  logic       addr_ok,
  output logic       cmd_reset,
  output logic       cal_begin,
  output logic       cal_end
);
  localparam int CW = $clog2(T_TIMEOUT + 2);

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_BRK, S_GAP, S_TX} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [2:0]    nbit;
  logic          is_data, bitval;
  logic [7:0]    sr, cmd, txsr;
  logic [7:0]    byte_in;

  assign byte_in  = {bitval, sr[7:1]};
  assign reg_addr = cmd[6:0];
  assign pull_low = (state == S_TX) &&
                    ((cnt < CW'(T_TXLOW)) || ((cnt < CW'(T_TXDATA)) && !txsr[0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      nbit      <= '0;
      is_data   <= 1'b0;
      bitval    <= 1'b0;
      sr        <= '0;
      cmd       <= '0;
      txsr      <= '0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      reg_rd    <= 1'b0;
      cmd_reset <= 1'b0;
      cal_begin <= 1'b0;
      cal_end   <= 1'b0;
    end else begin
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      cmd_reset <= 1'b0;
      cal_begin <= 1'b0;
      cal_end   <= 1'b0;
      case (state)
        S_IDLE: begin
          if (!line_in) begin
            state <= S_LOW;
            cnt   <= '0;
          end else if (us_tick && cnt != CW'(T_TIMEOUT)) begin
            cnt <= cnt + 1'b1;
          end else if (cnt == CW'(T_TIMEOUT)) begin
            nbit    <= '0;
            is_data <= 1'b0;
          end
        end
        S_LOW: begin
          if (us_tick) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(T_SAMP)) bitval <= line_in;
          end
          if (!line_in && cnt >= CW'(T_BREAK)) begin
            state   <= S_BRK;
            cnt     <= '0;
            nbit    <= '0;
            is_data <= 1'b0;
          end else if (line_in && cnt > CW'(T_SAMP)) begin
            state <= S_IDLE;
            cnt   <= '0;
            if (cnt > CW'(T_STOP)) begin
              nbit    <= '0;
              is_data <= 1'b0;
            end else begin
              sr   <= byte_in;
              nbit <= nbit + 1'b1;
              if (nbit == 3'd7) begin
                if (is_data) begin
                  is_data   <= 1'b0;
                  reg_wr    <= addr_ok;
                  reg_wdata <= byte_in;
                  if (addr_ok && cmd[6:0] == CMDW_ADDR) begin
                    cmd_reset <= (byte_in == CODE_RST);
                    cal_begin <= (byte_in == CODE_CAL_GO);
                    cal_end   <= (byte_in == CODE_CAL_END);
                  end
                end else begin
                  cmd <= byte_in;
                  if (byte_in[7]) is_data <= 1'b1;
                  else            state   <= S_GAP;
                end
              end
            end
          end
        end
        S_BRK: begin
          if (!line_in)                     cnt <= '0;
          else if (cnt >= CW'(T_RECOV)) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else if (us_tick)             cnt <= cnt + 1'b1;
        end
        S_GAP: if (us_tick) begin
          if (cnt == CW'(T_TURN - 1)) begin
            state  <= S_TX;
            cnt    <= '0;
            txsr   <= reg_rdata;
            reg_rd <= 1'b1;
            nbit   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_TX: if (us_tick) begin
          if (cnt == CW'(T_TXCYC - 1)) begin
            cnt  <= '0;
            txsr <= {1'b0, txsr[7:1]};
            nbit <= nbit + 1'b1;
            if (nbit == 3'd7) state <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_wr_after_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(state == S_LOW) && $past(line_in));

  assert_no_wr_in_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TX) |-> !reg_wr);

  assert_tx_frame_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_low) |-> (cnt == '0) && (state == S_TX));

  assert_break_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == S_BRK) |-> $past(!line_in) && nbit == '0 && !is_data);

  assert_invalid_no_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state == S_LOW) && !$past(addr_ok) |-> !reg_wr);

  assert_strobe_with_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_reset || cal_begin || cal_end) |-> reg_wr && reg_addr == CMDW_ADDR);

endmodule

// File: tb/tb_swire_slave.sv
`timescale 1ns/1ps
module tb_swire_slave;
  logic       clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0, host_lvl = 1'b1;
  logic       line_in, pull_low, reg_wr, reg_rd, addr_ok;
  logic       cmd_reset, cal_begin, cal_end;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [128];
  int checks = 0, errors = 0, n_wr = 0, n_rst = 0, n_go = 0, n_end = 0;

  localparam logic [6:0] CMDW = 7'h3F;

  always #5 clk = ~clk;
  always @(posedge clk) us_tick <= ~us_tick;

  assign line_in   = host_lvl & ~pull_low;
  assign addr_ok   = reg_addr < 7'h50;
  assign reg_rdata = mem[reg_addr];

  function automatic logic [7:0] pre(int i);
    return 8'(i * 3) ^ 8'hC3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= pre(i);
    end else begin
      if (reg_wr) begin mem[reg_addr] <= reg_wdata; n_wr <= n_wr + 1; end
      if (cmd_reset) n_rst <= n_rst + 1;
      if (cal_begin) n_go  <= n_go + 1;
      if (cal_end)   n_end <= n_end + 1;
    end
  end

  swire_slave dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .line_in(line_in),
    .pull_low(pull_low), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .addr_ok(addr_ok), .cmd_reset(cmd_reset), .cal_begin(cal_begin),
    .cal_end(cal_end)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input int lo1 = 10, input int lo0 = 110);
    int lo;
    lo = b ? lo1 : lo0;
    host_lvl = 1'b0;
    wait_us(lo);
    host_lvl = 1'b1;
    wait_us(200 - lo);
  endtask

  task automatic send_byte(input logic [7:0] v, input int lo1 = 10, input int lo0 = 110);
    for (int i = 0; i < 8; i++) send_bit(v[i], lo1, lo0);
  endtask

  task automatic write_txn(input logic [6:0] a, input logic [7:0] d);
    send_byte({1'b1, a});
    send_byte(d);
    wait_us(5);
  endtask

  task automatic read_txn(input logic [6:0] a, output logic [7:0] got,
                          output int lat_us, output int per_us);
    longint t0, t7;
    int w;
    send_byte({1'b0, a});
    got = '0; lat_us = 0; t0 = 0; t7 = 0;
    for (int i = 0; i < 8; i++) begin
      w = 0;
      while (!pull_low && w < 1000) begin @(negedge clk); w++; end
      if (i == 0) begin lat_us = w / 2; t0 = $time; end
      if (i == 7) t7 = $time;
      wait_us(60);
      got[i] = line_in;
      w = 0;
      while (pull_low && w < 1000) begin @(negedge clk); w++; end
    end
    per_us = int'((t7 - t0) / 7 / 20);
    wait_us(200);
  endtask

  task automatic t_reset;
    chk(pull_low == 1'b0, "R10 line released", pull_low, 0);
    chk({reg_wr, reg_rd, cmd_reset, cal_begin, cal_end} == 5'b0, "R10 pulses low",
        {reg_wr, reg_rd, cmd_reset, cal_begin, cal_end}, 0);
  endtask

  task automatic t_write_read;
    logic [7:0] got;
    int lat, per, w0;
    w0 = n_wr;
    write_txn(7'h12, 8'hC4);
    chk(mem[7'h12] == 8'hC4, "R1 R2 write lsb first", mem[7'h12], 8'hC4);
    chk(n_wr == w0 + 1, "R2 one write pulse", n_wr - w0, 1);
    read_txn(7'h12, got, lat, per);
    chk(got == 8'hC4, "R1 R3 read data", got, 8'hC4);
    chk(lat <= 320, "R3 first read bit latency", lat, 320);
    chk(per >= 190 && per <= 250, "R3 read bit cycle", per, 200);
  endtask

  task automatic t_read_preload;
    logic [7:0] got;
    int lat, per;
    read_txn(7'h21, got, lat, per);
    chk(got == pre(7'h21), "R3 read untouched register", got, pre(7'h21));
  endtask

  task automatic t_edge_timing;
    send_byte({1'b1, 7'h14}, 60, 140);
    send_byte(8'h5A, 60, 140);
    wait_us(5);
    chk(mem[7'h14] == 8'h5A, "R4 edge sample timing", mem[7'h14], 8'h5A);
  endtask

  task automatic t_invalid;
    int w0;
    w0 = n_wr;
    write_txn(7'h60, 8'h33);
    chk(n_wr == w0, "R7 invalid address write ignored", n_wr - w0, 0);
    write_txn(7'h13, 8'h44);
    chk(mem[7'h13] == 8'h44, "R7 next command accepted", mem[7'h13], 8'h44);
  endtask

  task automatic t_cmdword;
    write_txn(CMDW, 8'h78);
    chk(n_rst == 1 && n_go == 0 && n_end == 0, "R8 reset code", n_rst, 1);
    write_txn(CMDW, 8'h68);
    chk(n_go == 1 && n_end == 0, "R8 calibration start", n_go, 1);
    write_txn(CMDW, 8'h60);
    chk(n_end == 1 && n_go == 1, "R8 calibration stop", n_end, 1);
    write_txn(7'h10, 8'h78);
    chk(n_rst == 1, "R8 code to other address", n_rst, 1);
  endtask

  task automatic t_break;
    send_bit(1); send_bit(0); send_bit(1);
    host_lvl = 1'b0; wait_us(200);
    host_lvl = 1'b1; wait_us(50);
    write_txn(7'h05, 8'h3C);
    chk(mem[7'h05] == 8'h3C, "R6 break drops partial byte", mem[7'h05], 8'h3C);
  endtask

  task automatic t_short_recovery;
    host_lvl = 1'b0; wait_us(200);
    host_lvl = 1'b1; wait_us(20);
    send_bit(1);
    wait_us(50);
    write_txn(7'h07, 8'h11);
    chk(mem[7'h07] == 8'h11, "R6 edge during recovery ignored", mem[7'h07], 8'h11);
  endtask

  task automatic t_framing;
    send_bit(0); send_bit(1); send_bit(1);
    host_lvl = 1'b0; wait_us(160);
    host_lvl = 1'b1; wait_us(50);
    write_txn(7'h08, 8'h9E);
    chk(mem[7'h08] == 8'h9E, "R5 framing error drops byte", mem[7'h08], 8'h9E);
  endtask

  task automatic t_timeout;
    send_bit(1); send_bit(1); send_bit(0);
    wait_us(1100);
    write_txn(7'h09, 8'h6B);
    chk(mem[7'h09] == 8'h6B, "R9 idle timeout drops byte", mem[7'h09], 8'h6B);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    wait_us(50);
    t_reset;
    t_write_read;
    t_read_preload;
    t_edge_timing;
    t_invalid;
    t_cmdword;
    t_break;
    t_short_recovery;
    t_framing;
    t_timeout;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule